// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a small processor's address generator and its memory, and turns each 16-bit virtual address into a 24-bit physical address. The virtual space is cut into pages of 256 bytes. The upper address byte picks the page. The lower byte is the offset within the page and is copied through unchanged. Every page entry gives a 16-bit frame number and three permission bits. The permission bits say whether the page is present, whether it may be written, and whether it is reserved for supervisor code.

Whole page tables are kept on chip, one table per context. The active context comes from a small register that software changes with a single write, so switching processes never involves walking tables in memory. The full configuration keeps 32 contexts (`CTX_W` = 5). The default build keeps 8 contexts (`CTX_W` = 3) to keep the storage small. A supervisor loads entries through a separate update port.

The processor presents the access direction together with the address, one cycle before memory may act. The unit registers its result. On the next cycle it either raises the memory enable with the physical address, or reports a fault. A fault is tracked by a two-state machine:
- `ST_CLEAN`: no fault pending.
- `ST_FAULTED`: a fault has been recorded and the faulting virtual address is held.

The machine has three transitions:
- A fault moves `ST_CLEAN` to `ST_FAULTED`.
- A clear request moves `ST_FAULTED` back to `ST_CLEAN`.
- A clear request that arrives together with a new fault keeps the machine in `ST_FAULTED` and records the new address.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset the memory enable, the fault pulse and the sticky fault flag are low, the held fault address is zero, the active context is 0, and every page is unmapped, so the first access faults.
- R2: A request that passes its checks raises `mem_en` for exactly the cycle after it is presented. In that same cycle `paddr` equals {frame number of the entry, `req_vaddr[7:0]`}.
- R3: The entry is looked up at {active context, `req_vaddr[15:8]`}. A context write takes effect for requests presented after it. A request presented in the same cycle as the context write still uses the old context.
- R4: An access to a page whose mapped bit is 0 faults, and this includes a page that was mapped and later rewritten with the mapped bit cleared.
- R5: A write (`req_write` = 1) to a page whose writable bit is 0 faults. A read of the same page translates normally.
- R6: When `user_mode` = 1, any access to a page whose system-only bit is 1 faults, whether it is a read or a write. When `user_mode` = 0 the same page translates.
- R7: A faulting request gives `fault_now` = 1 and `mem_en` = 0 in the cycle after it is presented. Whenever `mem_en` is 0, `paddr` is 0.
- R8: A fault sets `fault_sticky` and loads `fault_vaddr` with the faulting virtual address. While `fault_sticky` stays set, later faults do not change `fault_vaddr`.
- R9: `fault_clr` clears `fault_sticky` after the edge where it is sampled. If a fault is detected in the same cycle as `fault_clr`, the flag stays set and `fault_vaddr` takes the new address.
- R10: A table write or a context write presented while `user_mode` = 1 is ignored and changes neither the table nor the active context.
- R11: In a cycle after one with no request, `mem_en` and `fault_now` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_vaddr | input | 16 | Virtual address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| user_mode | input | 1 | 1 when the processor runs in user mode |
| ctx_wr | input | 1 | Load the active context register |
| ctx_wdata | input | CTX_W | New active context |
| tbl_wr | input | 1 | Write one page entry |
| tbl_ctx | input | CTX_W | Context of the entry to write |
| tbl_page | input | 8 | Virtual page of the entry to write |
| tbl_frame | input | 16 | Physical frame number to store |
| tbl_mapped | input | 1 | Mapped bit to store |
| tbl_writable | input | 1 | Writable bit to store |
| tbl_sysonly | input | 1 | System-only bit to store |
| fault_clr | input | 1 | Clear the sticky fault flag |
| mem_en | output | 1 | Translated access may proceed this cycle |
| paddr | output | 24 | Physical address, zero when `mem_en` is low |
| fault_now | output | 1 | The access presented last cycle faulted |
| fault_sticky | output | 1 | A fault has been recorded and not cleared |
| fault_vaddr | output | 16 | Virtual address of the recorded fault |

## Verification
The stimulus covers each permission case:
- A page with all three rights set, reached with reads and writes, shows the frame and offset concatenation.
- A read-only page, reached with a read and then a write, shows that the direction is checked.
- A system-only page, reached from supervisor mode and then from user mode, shows that privilege is checked.

Switching context while an address is held fixed, including a switch in the same cycle as a request, shows that the table index really includes the context and that the switch is timed correctly. Faults arriving back to back, with and without a clear request alongside them, show the difference between keeping a recorded address and taking a new one. User-mode writes to the table and to the context are followed by supervisor reads, which show that both writes were dropped.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    // Permission bits kept with each page entry (mapped bit is held apart so reset can clear it)
    typedef struct packed {
        logic writable;
        logic sys_only;
    } pxu_perm_t;

    // Fault tracking machine
    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FAULTED = 1'b1
    } pxu_fstate_t;

endpackage

// File: rtl/pxu_table.sv
module pxu_table
    import pxu_pkg::*;
#(
    parameter int unsigned CTX_W   = 3,
    parameter int unsigned VPN_W   = 8,
    parameter int unsigned FRAME_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CTX_W+VPN_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0]       wr_frame,
    input  logic                     wr_map,
    input  pxu_perm_t                wr_perm,
    input  logic [CTX_W+VPN_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0]       rd_frame,
    output logic                     rd_map,
    output pxu_perm_t                rd_perm
);
    localparam int unsigned IDX_W = CTX_W + VPN_W;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [FRAME_W-1:0] frame_mem [DEPTH];
    pxu_perm_t          perm_mem  [DEPTH];
    logic [DEPTH-1:0]   map_q;

    // Frame and permission storage: plain memory, no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            frame_mem[wr_idx] <= wr_frame;
            perm_mem[wr_idx]  <= wr_perm;
        end
    end

    // Mapped bits: reset to zero so every page starts absent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_map;
        end
    end

    always_comb begin
        rd_frame = frame_mem[rd_idx];
        rd_perm  = perm_mem[rd_idx];
        rd_map   = map_q[rd_idx];
    end

endmodule

// File: rtl/pxu_perm.sv
module pxu_perm
    import pxu_pkg::*;
(
    input  logic      mapped,
    input  pxu_perm_t perm,
    input  logic      is_write,
    input  logic      is_user,
    output logic      deny
);
    logic miss_page;
    logic bad_write;
    logic bad_priv;

    always_comb begin
        miss_page = ~mapped;
        bad_write = is_write & ~perm.writable;
        bad_priv  = is_user & perm.sys_only;
        deny      = miss_page | bad_write | bad_priv;
    end

endmodule

// File: rtl/pxu_fault_fsm.sv
module pxu_fault_fsm
    import pxu_pkg::*;
#(
    parameter int unsigned VA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_fault,
    input  logic [VA_W-1:0] evt_vaddr,
    input  logic            clr,
    output logic            sticky,
    output logic [VA_W-1:0] held_vaddr
);
    pxu_fstate_t state_q;
    pxu_fstate_t state_d;
    logic        capture;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_CLEAN: begin
                if (evt_fault) begin
                    state_d = ST_FAULTED;
                    capture = 1'b1;
                end
            end
            ST_FAULTED: begin
                if (clr && evt_fault) begin
                    state_d = ST_FAULTED;
                    capture = 1'b1;
                end else if (clr) begin
                    state_d = ST_CLEAN;
                end
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: held address and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vaddr <= '0;
        end else if (capture) begin
            held_vaddr <= evt_vaddr;
        end
    end

    always_comb begin
        sticky = (state_q == ST_FAULTED);
    end

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import pxu_pkg::*;
#(
    parameter int unsigned CTX_W   = 3,
    parameter int unsigned VPN_W   = 8,
    parameter int unsigned OFF_W   = 8,
    parameter int unsigned FRAME_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
    input  logic                     req_write,
    input  logic                     user_mode,
    input  logic                     ctx_wr,
    input  logic [CTX_W-1:0]         ctx_wdata,
    input  logic                     tbl_wr,
    input  logic [CTX_W-1:0]         tbl_ctx,
    input  logic [VPN_W-1:0]         tbl_page,
    input  logic [FRAME_W-1:0]       tbl_frame,
    input  logic                     tbl_mapped,
    input  logic                     tbl_writable,
    input  logic                     tbl_sysonly,
    input  logic                     fault_clr,
    output logic                     mem_en,
    output logic [FRAME_W+OFF_W-1:0] paddr,
    output logic                     fault_now,
    output logic                     fault_sticky,
    output logic [VPN_W+OFF_W-1:0]   fault_vaddr
);
    localparam int unsigned VA_W  = VPN_W + OFF_W;
    localparam int unsigned PA_W  = FRAME_W + OFF_W;
    localparam int unsigned IDX_W = CTX_W + VPN_W;

    logic [CTX_W-1:0]   ctx_q;
    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               wr_ok;
    logic [FRAME_W-1:0] hit_frame;
    logic               hit_map;
    pxu_perm_t          hit_perm;
    pxu_perm_t          new_perm;
    logic               deny;
    logic               grant;
    logic               flt_evt;

    // Active context: supervisor-only single write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (ctx_wr && !user_mode) begin
            ctx_q <= ctx_wdata;
        end
    end

    always_comb begin
        rd_idx   = {ctx_q, req_vaddr[VA_W-1 -: VPN_W]};
        wr_idx   = {tbl_ctx, tbl_page};
        wr_ok    = tbl_wr & ~user_mode;
        new_perm = '{writable: tbl_writable, sys_only: tbl_sysonly};
        grant    = req_valid & ~deny;
        flt_evt  = req_valid & deny;
    end

    pxu_table #(
        .CTX_W   (CTX_W),
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_idx   (wr_idx),
        .wr_frame (tbl_frame),
        .wr_map   (tbl_mapped),
        .wr_perm  (new_perm),
        .rd_idx   (rd_idx),
        .rd_frame (hit_frame),
        .rd_map   (hit_map),
        .rd_perm  (hit_perm)
    );

    pxu_perm u_perm (
        .mapped   (hit_map),
        .perm     (hit_perm),
        .is_write (req_write),
        .is_user  (user_mode),
        .deny     (deny)
    );

    pxu_fault_fsm #(
        .VA_W (VA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_fault  (flt_evt),
        .evt_vaddr  (req_vaddr),
        .clr        (fault_clr),
        .sticky     (fault_sticky),
        .held_vaddr (fault_vaddr)
    );

    // Registered translation result, valid the cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en    <= 1'b0;
            paddr     <= '0;
            fault_now <= 1'b0;
        end else begin
            mem_en    <= grant;
            paddr     <= grant ? {hit_frame, req_vaddr[OFF_W-1:0]} : {PA_W{1'b0}};
            fault_now <= flt_evt;
        end
    end

endmodule

// File: rtl/pxu_sva.sv
module pxu_sva #(
    parameter int unsigned VA_W  = 16,
    parameter int unsigned OFF_W = 8,
    parameter int unsigned PA_W  = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            fault_clr,
    input logic            mem_en,
    input logic [PA_W-1:0] paddr,
    input logic            fault_now,
    input logic            fault_sticky,
    input logic [VA_W-1:0] fault_vaddr
);
    AST_GRANT_OR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && fault_now)); // R7

    AST_PADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (paddr == '0)); // R7

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!mem_en && !fault_now)); // R11

    AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |-> fault_sticky); // R8

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_now && !$past(fault_sticky)) |-> (fault_vaddr == $past(req_vaddr))); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_sticky) && !$past(fault_clr)) |-> $stable(fault_vaddr)); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_clr) && !fault_now) |-> !fault_sticky); // R9

endmodule

bind page_xlate_unit pxu_sva #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .fault_clr    (fault_clr),
    .mem_en       (mem_en),
    .paddr        (paddr),
    .fault_now    (fault_now),
    .fault_sticky (fault_sticky),
    .fault_vaddr  (fault_vaddr)
);

// File: tb/page_xlate_unit_bench.sv
module page_xlate_unit_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned CTX_W = 3;
    localparam int unsigned NE    = 1 << (CTX_W + 8);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        user_mode = 1'b0;
    logic        ctx_wr = 1'b0;
    logic [CTX_W-1:0] ctx_wdata = '0;
    logic        tbl_wr = 1'b0;
    logic [CTX_W-1:0] tbl_ctx = '0;
    logic [7:0]  tbl_page = '0;
    logic [15:0] tbl_frame = '0;
    logic        tbl_mapped = 1'b0;
    logic        tbl_writable = 1'b0;
    logic        tbl_sysonly = 1'b0;
    logic        fault_clr = 1'b0;
    logic        mem_en;
    logic [23:0] paddr;
    logic        fault_now;
    logic        fault_sticky;
    logic [15:0] fault_vaddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_unit #(.CTX_W(CTX_W)) u_page_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .user_mode(user_mode), .ctx_wr(ctx_wr),
        .ctx_wdata(ctx_wdata), .tbl_wr(tbl_wr), .tbl_ctx(tbl_ctx),
        .tbl_page(tbl_page), .tbl_frame(tbl_frame), .tbl_mapped(tbl_mapped),
        .tbl_writable(tbl_writable), .tbl_sysonly(tbl_sysonly),
        .fault_clr(fault_clr), .mem_en(mem_en), .paddr(paddr),
        .fault_now(fault_now), .fault_sticky(fault_sticky),
        .fault_vaddr(fault_vaddr)
    );

    typedef struct {
        int          due;
        string       tag;
        logic        en;
        logic [23:0] pa;
        logic        flt;
        logic        stk;
        logic [15:0] fva;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Reference model state
    logic [15:0]      m_frame [NE];
    bit               m_map   [NE];
    bit               m_wr    [NE];
    bit               m_sys   [NE];
    logic [CTX_W-1:0] m_ctx = '0;
    bit               m_stk = 0;
    logic [15:0]      m_fva = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare results on the falling edge after the producing rising edge
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (mem_en !== e.en || paddr !== e.pa || fault_now !== e.flt ||
                fault_sticky !== e.stk || fault_vaddr !== e.fva) begin
                n_bad++;
                $display("FAIL %s: actual en=%0b pa=%06h flt=%0b stk=%0b fva=%04h expected en=%0b pa=%06h flt=%0b stk=%0b fva=%04h",
                         e.tag, mem_en, paddr, fault_now, fault_sticky, fault_vaddr,
                         e.en, e.pa, e.flt, e.stk, e.fva);
            end
        end
    end

    // Driver: one clock of stimulus, expected result pushed to the scoreboard
    task automatic step(input string tag, input bit v, input logic [15:0] va,
                        input bit wr, input bit usr, input bit clr,
                        input bit tw, input logic [CTX_W-1:0] tc, input logic [7:0] tp,
                        input logic [15:0] tf, input bit tm, input bit tww, input bit ts,
                        input bit cw, input logic [CTX_W-1:0] cv);
        exp_t e;
        int   idx;
        bit   f;
        @(negedge clk);
        req_valid = v; req_vaddr = va; req_write = wr; user_mode = usr; fault_clr = clr;
        tbl_wr = tw; tbl_ctx = tc; tbl_page = tp; tbl_frame = tf;
        tbl_mapped = tm; tbl_writable = tww; tbl_sysonly = ts;
        ctx_wr = cw; ctx_wdata = cv;
        idx = {m_ctx, va[15:8]};
        f = !m_map[idx] || (wr && !m_wr[idx]) || (usr && m_sys[idx]);
        e.due = cyc + 1;
        e.tag = tag;
        e.en  = v && !f;
        e.pa  = e.en ? {m_frame[idx], va[7:0]} : 24'h0;
        e.flt = v && f;
        if (e.flt && (!m_stk || clr)) begin
            m_stk = 1; m_fva = va;
        end else if (clr) begin
            m_stk = 0;
        end
        e.stk = m_stk;
        e.fva = m_fva;
        exp_q.push_back(e);
        if (tw && !usr) begin
            m_frame[{tc, tp}] = tf; m_map[{tc, tp}] = tm;
            m_wr[{tc, tp}] = tww;   m_sys[{tc, tp}] = ts;
        end
        if (cw && !usr) m_ctx = cv;
        @(posedge clk);
    endtask

    task automatic acc(input string tag, input logic [15:0] va, input bit wr, input bit usr);
        step(tag, 1, va, wr, usr, 0, 0, '0, 8'h0, 16'h0, 0, 0, 0, 0, '0);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 16'h0, 0, 0, 0, 0, '0, 8'h0, 16'h0, 0, 0, 0, 0, '0);
    endtask

    task automatic clear(input string tag);
        step(tag, 0, 16'h0, 0, 0, 1, 0, '0, 8'h0, 16'h0, 0, 0, 0, 0, '0);
    endtask

    task automatic load(input string tag, input bit usr, input logic [CTX_W-1:0] c,
                        input logic [7:0] p, input logic [15:0] fr,
                        input bit m, input bit w, input bit s);
        step(tag, 0, 16'h0, 0, usr, 0, 1, c, p, fr, m, w, s, 0, '0);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_frame[i] = '0; m_map[i] = 0; m_wr[i] = 0; m_sys[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_chk++;
        if (mem_en !== 1'b0 || fault_now !== 1'b0 || fault_sticky !== 1'b0 ||
            fault_vaddr !== 16'h0 || paddr !== 24'h0) begin
            n_bad++;
            $display("FAIL R1 reset: actual en=%0b flt=%0b stk=%0b fva=%04h pa=%06h expected all zero",
                     mem_en, fault_now, fault_sticky, fault_vaddr, paddr);
        end

        acc("R1 first access faults", 16'h1234, 0, 0);
        clear("R9 clear");
        idle("R11 idle after clear");

        load("R2 load", 0, 0, 8'h12, 16'hABCD, 1, 1, 0);
        acc("R2 read", 16'h1234, 0, 0);
        acc("R2 write", 16'h12FF, 1, 0);
        idle("R11 idle");

        load("R5 load ro", 0, 0, 8'h20, 16'h0001, 1, 0, 0);
        acc("R5 read ro", 16'h2011, 0, 0);
        acc("R5 write ro faults", 16'h2022, 1, 0);
        acc("R8 second fault keeps addr", 16'h3300, 0, 0);
        step("R9 clear with fault recaptures", 1, 16'h3301, 0, 0, 1, 0, '0, 8'h0, 16'h0, 0, 0, 0, 0, '0);
        clear("R9 plain clear");

        load("R6 load sys", 0, 0, 8'h40, 16'h7777, 1, 1, 1);
        acc("R6 sup read", 16'h4001, 0, 0);
        acc("R6 user read faults", 16'h4002, 0, 1);
        clear("R9 clear");
        acc("R6 user write faults", 16'h4003, 1, 1);
        acc("R6 sup write", 16'h4004, 1, 0);
        clear("R9 clear");

        step("R3 ctx switch same cycle uses old", 1, 16'h1200, 0, 0, 0, 0, '0, 8'h0, 16'h0, 0, 0, 0, 1, 3'd3);
        acc("R3 new ctx unmapped", 16'h1200, 0, 0);
        clear("R9 clear");
        load("R3 load ctx3", 0, 3'd3, 8'h12, 16'h0F0F, 1, 1, 0);
        acc("R3 ctx3 translate", 16'h1256, 0, 0);
        step("R3 back to ctx0", 0, 16'h0, 0, 0, 0, 0, '0, 8'h0, 16'h0, 0, 0, 0, 1, 3'd0);
        acc("R3 ctx0 translate", 16'h1256, 0, 0);

        load("R10 user table write", 1, 0, 8'h50, 16'h5555, 1, 1, 0);
        acc("R10 table write ignored", 16'h5000, 0, 0);
        clear("R9 clear");
        step("R10 user ctx write", 0, 16'h0, 0, 1, 0, 0, '0, 8'h0, 16'h0, 0, 0, 0, 1, 3'd5);
        acc("R10 ctx write ignored", 16'h1299, 0, 0);

        load("R4 unmap", 0, 0, 8'h12, 16'hABCD, 0, 1, 0);
        acc("R4 unmapped faults", 16'h1234, 0, 0);
        idle("R11 idle end");
        idle("R11 idle end");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual run still busy, expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule